// File: doc/BRIEF.md
# Multi-channel prescaled PWM generator

A bank of independent pulse-width modulators that all run from one reference clock. Each channel divides the reference clock by a selectable ratio to make ticks. It counts ticks over a programmable period, and at two programmable tick positions it switches its pin between two selectable drive levels. Each drive level is low, high or released (high-impedance). A released pin is signalled by deasserting that channel's output-enable.

Software programs the bank through a single-cycle write port. A control word holds one run bit per channel. Two alias addresses set or clear chosen run bits and leave the other bits alone. Each channel also has an edge word and a period word. The edge word is held in a shadow register and does nothing by itself. Writing the period word stages the shadow edge values together with the new period settings. The staged set replaces the live configuration at the end of the current cycle, or almost at once while the channel is stopped. A waveform is therefore never built from half of an old configuration and half of a new one.

Top module: `pwm_bank`

## Requirements
- R1: After reset every channel is stopped, its live configuration is all zero, and every pin drives 0 with its output-enable high.
- R2: The 3-bit divide code in period-word bits [22:20] selects ticks of 1, 2, 4, 8, 16, 64, 256 or 1024 reference clocks for codes 0 to 7. No code gives 32 or 128.
- R3: A period field value N in period-word bits [15:0] gives a repeating cycle of N+1 ticks, numbered 0 to N. N = 0 is legal and gives a one-tick cycle.
- R4: The edge word has two fields. The rise position is in bits [15:0] and the fall position is in bits [31:16]. At the tick equal to the rise position the pin takes the active level. At the tick equal to the fall position it takes the idle level. If both positions are equal, the idle level wins. Between edges the pin holds its level.
- R5: The active level is in period-word bits [17:16] and the idle level is in bits [19:18]. Code 0 drives 0, code 1 drives 1, and codes 2 and 3 release the pin with output-enable low.
- R6: A write to address 0 loads the run bits directly. Bit c of the data controls channel c.
- R7: A write to address 1 sets the run bits where the data has ones. A write to address 2 clears the run bits where the data has ones. Both leave every other run bit unchanged.
- R8: A write to a channel's edge word (address 4+2c) alone never changes that channel's waveform.
- R9: A write to a channel's period word (address 5+2c) while the channel runs takes effect, together with the shadow edge values, from tick 0 of the next cycle.
- R10: A period-word write to a stopped channel takes effect by the second clock edge after the write.
- R11: A stopped channel holds its tick and prescale counters at zero and shows its idle level. On start it begins at tick 0, prescale count 0, and starts from the idle level before any edge.
- R12: With rise position 0, active level 1, idle level 0, and fall position P·d/100 for a P-tick cycle, the pin is high for d percent of each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Write data |
| pwm_o | output | NCH | Per-channel pin data level |
| pwm_oe | output | NCH | Per-channel pin output-enable, low when released |

## Verification
A table of channel setups covers every divide code, one-tick and hundred-tick cycles, edges in both orders, coincident edges, active-low waveforms and released levels. Each setup is compared cycle by cycle over two full cycles against a bench model. Together these separate a wrong divide ratio, an off-by-one period, a wrong edge priority and a wrong level decode. Directed sequences cover the rest. One writes an edge word mid-cycle and shows the old waveform continuing. Another writes the period word and shows the change landing exactly on the next tick 0. Others use the set and clear aliases on chosen bits while the untouched channels keep running, and show that a stopped channel adopts a new idle level without being started.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    localparam int POS_W  = 16;
    localparam int CODE_W = 3;
    localparam int LVL_W  = 2;
    localparam int PRE_W  = 10;

    // edge word: fall position high half, rise position low half
    typedef struct packed {
        logic [POS_W-1:0] fall_pos;
        logic [POS_W-1:0] rise_pos;
    } edge_cfg_t;

    // period word bits [22:0]
    typedef struct packed {
        logic [CODE_W-1:0] div_code;
        logic [LVL_W-1:0]  idle_lvl;
        logic [LVL_W-1:0]  act_lvl;
        logic [POS_W-1:0]  last_tick;
    } per_cfg_t;

    localparam int PER_BITS = $bits(per_cfg_t);

    function automatic int unsigned div_shift(input logic [CODE_W-1:0] code);
        case (code)
            3'd0:    return 0;
            3'd1:    return 1;
            3'd2:    return 2;
            3'd3:    return 3;
            3'd4:    return 4;
            3'd5:    return 6;
            3'd6:    return 8;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/pwm_ctrl_reg.sv
module pwm_ctrl_reg #(
    parameter int NCH    = 4,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NCH-1:0]    wr_bits,
    output logic [NCH-1:0]    run,
    output logic [NCH-1:0]    edge_we,
    output logic [NCH-1:0]    per_we
);

    localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(2);
    localparam int                CH_BASE = 4;

    logic [NCH-1:0] run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (wr_en) begin
            case (wr_addr)
                A_LOAD:  run_d = wr_bits;
                A_SET:   run_d = run_q | wr_bits;
                A_CLR:   run_d = run_q & ~wr_bits;
                default: run_d = run_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    assign run = run_q;

    for (genvar c = 0; c < NCH; c++) begin : g_dec
        assign edge_we[c] = wr_en && (wr_addr == ADDR_W'(CH_BASE + 2*c));
        assign per_we[c]  = wr_en && (wr_addr == ADDR_W'(CH_BASE + 2*c + 1));
    end

    p_set_alias_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_SET) |=> ((run_q & $past(wr_bits)) == $past(wr_bits))
                                       && ((run_q & ~$past(wr_bits)) == ($past(run_q) & ~$past(wr_bits))));

    p_clr_alias_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_CLR) |=> ((run_q & $past(wr_bits)) == '0)
                                       && ((run_q & ~$past(wr_bits)) == ($past(run_q) & ~$past(wr_bits))));

    p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_LOAD) |=> (run_q == $past(wr_bits)));

    p_one_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({edge_we, per_we}));

endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale
    import pwm_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              tick_end
);

    logic [PRE_W-1:0] cnt_d, cnt_q;
    logic [PRE_W-1:0] lim;
    logic [PRE_W-1:0] all_ones;

    assign all_ones = '1;

    always_comb begin
        lim      = all_ones >> (PRE_W - int'(div_shift(code)));
        tick_end = run && (cnt_q == lim);
        if (!run || tick_end) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    p_pre_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim);

    p_pre_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0);

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_bank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              edge_we,
    input  logic              per_we,
    input  logic [DATA_W-1:0] wdata,
    output logic              pad_o,
    output logic              pad_oe
);

    typedef struct packed {
        edge_cfg_t        sh_edge;
        edge_cfg_t        stg_edge;
        per_cfg_t         stg_per;
        logic             pend;
        edge_cfg_t        wk_edge;
        per_cfg_t         wk_per;
        logic [POS_W-1:0] tick;
        logic             phase;
    } chan_st_t;

    chan_st_t s_d, s_q;

    logic             tick_end;
    logic             wrap;
    logic             commit;
    logic             ph_now;
    logic [LVL_W-1:0] lvl;

    pwm_prescale u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .code     (s_q.wk_per.div_code),
        .tick_end (tick_end)
    );

    always_comb begin
        s_d    = s_q;
        wrap   = tick_end && (s_q.tick == s_q.wk_per.last_tick);
        commit = s_q.pend && (!run || wrap);

        // rising edge has lower priority than falling edge
        if (!run)                                   ph_now = 1'b0;
        else if (s_q.tick == s_q.wk_edge.fall_pos)  ph_now = 1'b0;
        else if (s_q.tick == s_q.wk_edge.rise_pos)  ph_now = 1'b1;
        else                                        ph_now = s_q.phase;
        s_d.phase = ph_now;

        if (!run)          s_d.tick = '0;
        else if (wrap)     s_d.tick = '0;
        else if (tick_end) s_d.tick = s_q.tick + 1'b1;

        if (edge_we) s_d.sh_edge = edge_cfg_t'(wdata[2*POS_W-1:0]);

        if (commit) begin
            s_d.wk_edge = s_q.stg_edge;
            s_d.wk_per  = s_q.stg_per;
            s_d.pend    = 1'b0;
        end

        if (per_we) begin
            s_d.stg_edge = s_q.sh_edge;
            s_d.stg_per  = per_cfg_t'(wdata[PER_BITS-1:0]);
            s_d.pend     = 1'b1;
        end

        lvl    = ph_now ? s_q.wk_per.act_lvl : s_q.wk_per.idle_lvl;
        pad_oe = ~lvl[1];
        pad_o  = (lvl == 2'd1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    p_tick_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> s_q.tick <= s_q.wk_per.last_tick);

    p_stop_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (s_q.tick == '0) && !s_q.phase);

    p_stop_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (pad_oe == !s_q.wk_per.idle_lvl[1]));

    p_edge_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_we && !s_q.pend) |=> $stable(s_q.wk_edge) && $stable(s_q.wk_per));

    p_hold_until_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wrap) |=> $stable(s_q.wk_per) && $stable(s_q.wk_edge));

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank #(
    parameter int NCH    = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [NCH-1:0]    pwm_o,
    output logic [NCH-1:0]    pwm_oe
);

    localparam int LAST_ADDR = 4 + 2*NCH - 1;

    logic [NCH-1:0] run;
    logic [NCH-1:0] edge_we;
    logic [NCH-1:0] per_we;

    initial begin
        if (LAST_ADDR >= (1 << ADDR_W)) $error("ADDR_W too small for NCH");
        if (DATA_W < 32)                $error("DATA_W must be at least 32");
    end

    pwm_ctrl_reg #(
        .NCH    (NCH),
        .ADDR_W (ADDR_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_bits (wr_data[NCH-1:0]),
        .run     (run),
        .edge_we (edge_we),
        .per_we  (per_we)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pwm_chan #(
            .DATA_W (DATA_W)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (run[c]),
            .edge_we (edge_we[c]),
            .per_we  (per_we[c]),
            .wdata   (wr_data),
            .pad_o   (pwm_o[c]),
            .pad_oe  (pwm_oe[c])
        );
    end

endmodule

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int NV  = 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [3:0]     wr_addr = '0;
    logic [31:0]    wr_data = '0;
    logic [NCH-1:0] pwm_o, pwm_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_bank #(.NCH(NCH), .DATA_W(32), .ADDR_W(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_o(pwm_o), .pwm_oe(pwm_oe)
    );

    // {code[54:52], last[51:36], rise[35:20], fall[19:4], act[3:2], idle[1:0]}
    localparam logic [54:0] VEC [NV] = '{
        {3'd0, 16'd4,  16'd0, 16'd2,  2'd1, 2'd0},
        {3'd1, 16'd3,  16'd1, 16'd3,  2'd1, 2'd0},
        {3'd4, 16'd1,  16'd0, 16'd1,  2'd1, 2'd2},
        {3'd5, 16'd1,  16'd0, 16'd1,  2'd1, 2'd0},
        {3'd7, 16'd1,  16'd0, 16'd1,  2'd1, 2'd0},
        {3'd0, 16'd9,  16'd3, 16'd3,  2'd1, 2'd0},
        {3'd0, 16'd99, 16'd0, 16'd25, 2'd1, 2'd0},
        {3'd2, 16'd2,  16'd2, 16'd0,  2'd0, 2'd1},
        {3'd3, 16'd0,  16'd0, 16'd5,  2'd1, 2'd0},
        {3'd6, 16'd1,  16'd1, 16'd0,  2'd3, 2'd1}
    };

    function automatic int ref_div(input logic [2:0] code);
        case (code)
            3'd0: return 1;    3'd1: return 2;   3'd2: return 4;   3'd3: return 8;
            3'd4: return 16;   3'd5: return 64;  3'd6: return 256; default: return 1024;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] per_word(input logic [2:0] code, input logic [1:0] idle,
                                             input logic [1:0] actl, input logic [15:0] last);
        return {9'd0, code, idle, actl, last};
    endfunction

    // expected {oe, out} for a level code; out don't-care when released
    function automatic logic [1:0] lvl_pins(input logic [1:0] l);
        return {~l[1], l == 2'd1};
    endfunction

    initial begin : watchdog
        #(CLK_PERIOD * 190000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        #(CLK_PERIOD * 3);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 reset pins", {pwm_oe, pwm_o}, {4'hF, 4'h0});

        // table walk on channel 0: R2 R3 R4 R5 R11 R12
        for (int v = 0; v < NV; v++) begin
            logic [2:0]  code;
            logic [15:0] last, rise, fall;
            logic [1:0]  al, il;
            int          dv, ncyc, bad, t;
            logic        st;
            logic [1:0]  exp_p, act_p;
            {code, last, rise, fall, al, il} = VEC[v];
            dv   = ref_div(code);
            ncyc = 2 * (int'(last) + 1) * dv;
            wr(4'd0, 32'd0);
            wr(4'd4, {fall, rise});
            wr(4'd5, per_word(code, il, al, last));
            step();
            wr(4'd1, 32'd1);
            bad = 0; st = 1'b0;
            exp_p = '0; act_p = '0;
            for (int i = 0; i < ncyc; i++) begin
                t = (i / dv) % (int'(last) + 1);
                if (t == int'(fall))      st = 1'b0;
                else if (t == int'(rise)) st = 1'b1;
                exp_p = lvl_pins(st ? al : il);
                act_p = {pwm_oe[0], pwm_o[0]};
                if (act_p[1] !== exp_p[1] || (exp_p[1] && act_p[0] !== exp_p[0])) begin
                    if (bad == 0)
                        $display("FAIL R2/R3/R4/R5/R12 vector %0d cycle %0d: actual %b expected %b",
                                 v, i, act_p, exp_p);
                    bad++;
                end
                step();
            end
            n_chk++;
            if (bad != 0) n_fail++;
        end
        // R12 is the 25% vector (index 6), R2 covers codes 0..7 above

        // R11: stopped channel shows idle level (last vector idle level 1)
        wr(4'd0, 32'd0);
        check("R11 stopped shows idle", {pwm_oe[0], pwm_o[0]}, 2'b11);

        // R10: period write to stopped channel 3, idle released
        wr(4'd10, {16'd2, 16'd0});
        wr(4'd11, per_word(3'd0, 2'd2, 2'd1, 16'd3));
        step();
        check("R10 stopped commit", {31'd0, pwm_oe[3]}, 32'd0);

        // channels 1 and 2: rise 0, fall 2, 4 ticks
        wr(4'd6, {16'd2, 16'd0});
        wr(4'd7, per_word(3'd0, 2'd0, 2'd1, 16'd3));
        wr(4'd8, {16'd2, 16'd0});
        wr(4'd9, per_word(3'd0, 2'd0, 2'd1, 16'd3));
        step();

        // R7: set alias
        wr(4'd1, 32'h6);
        check("R7 set alias", {29'd0, pwm_oe[3], pwm_o[2:1]}, {29'd0, 3'b011});
        // R7: clear alias leaves channel 2 running
        wr(4'd2, 32'h2);
        check("R7 clear alias", {30'd0, pwm_o[2:1]}, {30'd0, 2'b10});
        // R6: direct load
        wr(4'd0, 32'h2);
        check("R6 direct load", {30'd0, pwm_o[2:1]}, {30'd0, 2'b01});

        // R8 / R9: staged commit on channel 1
        wr(4'd0, 32'd0);
        wr(4'd6, {16'd4, 16'd0});
        wr(4'd7, per_word(3'd0, 2'd0, 2'd1, 16'd7));
        step();
        wr(4'd1, 32'h2);             // sample i = 0
        wr(4'd6, {16'd2, 16'd0});    // i = 1
        wr(4'd7, per_word(3'd0, 2'd0, 2'd1, 16'd7)); // i = 2
        for (int i = 2; i < 16; i++) begin
            logic e;
            e = (i < 8) ? ((i % 8) < 4) : ((i % 8) < 2);
            if (i < 8) check("R8 old waveform kept", {31'd0, pwm_o[1]}, {31'd0, e});
            else       check("R9 new at next tick 0", {31'd0, pwm_o[1]}, {31'd0, e});
            if (i < 15) step();
        end
        wr(4'd6, {16'd6, 16'd0});    // i = 16, edge only
        for (int i = 16; i < 32; i++) begin
            check("R8 edge alone ignored", {31'd0, pwm_o[1]}, {31'd0, (i % 8) < 2});
            step();
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule